// File: doc/BRIEF.md
# Auxiliary PWM Generator with Deferred Reload

This block produces a single pulse-width-modulated output from a 32-bit up-counter and two comparison values: a period limit and a compare threshold. Software reaches it through a small register port with a write strobe, a byte address and a combinational read-back. A control register starts and stops the counter, gates the output, and selects whether the compare value sets the high time or the low time of each period.

Each of the period and compare values has two copies. The live copy drives the waveform. The staged copy can be written while the waveform runs, and it is copied into the live copy only when the counter wraps. A running output can therefore be reprogrammed without a truncated or stretched period. A direct write to a live value takes effect at once and cancels any staged transfer that is still waiting.

Top module: `aux_pwm`

## Requirements
- R1: After a synchronous active-low reset, every register reads 0, the counter reads 0 and `pwm_out` is low.
- R2: While control bit 4 (run) is set, the counter steps up by one each cycle. On the cycle after it reaches or passes the live period P, it returns to 0. Each waveform period is therefore P+1 cycles long.
- R3: Clearing the run bit sets the counter to 0 on the next cycle, and the counter then holds at 0.
- R4: With control bit 10 (polarity) clear, `pwm_out` is high in a cycle exactly when the counter value of the previous cycle is below the live compare C. Each period then has min(C, P+1) high cycles.
- R5: With control bit 10 set, the output of R4 is inverted, so C sets the low time of each period.
- R6: While control bit 9 (output mode) is clear, `pwm_out` is low one cycle later, whatever the counter and compare hold.
- R7: A write to a staged register (offset 0x0C for period, 0x10 for compare) leaves the live values unchanged until the counter wraps. At the wrap, both staged values are copied into the live registers.
- R8: A write to a live register (offset 0x04 for period, 0x08 for compare) takes effect on the next cycle and cancels any pending staged transfer. The staged register keeps its value.
- R9: A period of 1 with a compare of 1 gives a two-cycle waveform with one high cycle.
- R10: The control register sits at offset 0x00 and holds 16 bits that read back as written. Bits 7:6 (sync select) are stored but do not affect the output. The counter reads at offset 0x14, and unmapped offsets read 0.
- R11: When C exceeds P, the output stays high for the whole period under normal polarity, and low under inverted polarity.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| pwm_out | output | 1 | Registered PWM output |

## Verification
The assertions rely on the register port carrying at most one write per cycle. Because of this, a live-register write and a staged-register write never arrive in the same cycle. The transfer and hold properties also assume that the address holds only during a strobe cycle. The bench drives one write at a time, each on a falling edge and held for exactly one cycle. It measures the waveform over whole multiples of the period, so the measured high count does not depend on where the counter stood when the window opened.

// File: rtl/aux_pwm_pkg.sv
// Package: shared widths, register offsets and control bit positions for aux_pwm.
// Assumes a byte-addressed register port with one 32-bit word per offset.
package aux_pwm_pkg;
    localparam int DATA_W     = 32;
    localparam int CTRL_W     = 16;
    localparam int ADDR_W     = 5;

    localparam int OFF_CTRL   = 'h00;
    localparam int OFF_PER    = 'h04;
    localparam int OFF_CMP    = 'h08;
    localparam int OFF_PER_SH = 'h0C;
    localparam int OFF_CMP_SH = 'h10;
    localparam int OFF_COUNT  = 'h14;

    localparam int BIT_RUN    = 4;
    localparam int BIT_MODE   = 9;
    localparam int BIT_POL    = 10;
endpackage

// File: rtl/aux_pwm_regs.sv
// Module: register file with live and staged period/compare and control.
// Assumes at most one write per cycle; the wrap pulse comes from the counter.
module aux_pwm_regs
    import aux_pwm_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int CW = CTRL_W,
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic          wrap,
    input  logic [DW-1:0] count,
    output logic [CW-1:0] ctrl,
    output logic [DW-1:0] per_live,
    output logic [DW-1:0] cmp_live
);
    localparam int PAD_W = DW - CW;

    logic [DW-1:0] per_stage, cmp_stage;
    logic          pending;
    logic          wr_ctrl, wr_per, wr_cmp, wr_per_sh, wr_cmp_sh, wr_live, wr_stage;

    // Decode the single write strobe into per-register enables.
    always_comb begin
        wr_ctrl   = bus_wr && (bus_addr == AW'(OFF_CTRL));
        wr_per    = bus_wr && (bus_addr == AW'(OFF_PER));
        wr_cmp    = bus_wr && (bus_addr == AW'(OFF_CMP));
        wr_per_sh = bus_wr && (bus_addr == AW'(OFF_PER_SH));
        wr_cmp_sh = bus_wr && (bus_addr == AW'(OFF_CMP_SH));
        wr_live   = wr_per || wr_cmp;
        wr_stage  = wr_per_sh || wr_cmp_sh;
    end

    // Control register: plain 16-bit storage.
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl <= '0;
        else if (wr_ctrl) ctrl <= bus_wdata[CW-1:0];
    end

    // Staged registers: written by software only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            per_stage <= '0;
            cmp_stage <= '0;
        end else begin
            if (wr_per_sh) per_stage <= bus_wdata;
            if (wr_cmp_sh) cmp_stage <= bus_wdata;
        end
    end

    // Live registers: direct write wins over a wrap-time transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            per_live <= '0;
            cmp_live <= '0;
        end else if (wr_live) begin
            if (wr_per) per_live <= bus_wdata;
            if (wr_cmp) cmp_live <= bus_wdata;
        end else if (wrap && pending) begin
            per_live <= per_stage;
            cmp_live <= cmp_stage;
        end
    end

    // Pending flag: set by a staged write, cleared by a transfer or a live write.
    always_ff @(posedge clk) begin
        if (!rst_n)        pending <= 1'b0;
        else if (wr_stage) pending <= 1'b1;
        else if (wr_live)  pending <= 1'b0;
        else if (wrap)     pending <= 1'b0;
    end

    // Read mux: combinational, unmapped offsets return zero.
    always_comb begin
        case (bus_addr)
            AW'(OFF_CTRL):   bus_rdata = {{PAD_W{1'b0}}, ctrl};
            AW'(OFF_PER):    bus_rdata = per_live;
            AW'(OFF_CMP):    bus_rdata = cmp_live;
            AW'(OFF_PER_SH): bus_rdata = per_stage;
            AW'(OFF_CMP_SH): bus_rdata = cmp_stage;
            AW'(OFF_COUNT):  bus_rdata = count;
            default:         bus_rdata = '0;
        endcase
    end

    // R8: a live write leaves nothing pending
    a_r8_live_write_cancels: assert property (@(posedge clk) disable iff (!rst_n)
        wr_live |=> !pending);

    // R7: a staged write away from a wrap keeps the live pair unchanged
    a_r7_stage_holds_live: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stage && !wrap) |=> ($stable(per_live) && $stable(cmp_live)));

    // R7: at a wrap with a pending transfer the staged pair lands in the live pair
    a_r7_wrap_transfers: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && pending && !bus_wr) |=>
            (per_live == $past(per_stage) && cmp_live == $past(cmp_stage) && !pending));
endmodule

// File: rtl/aux_pwm_counter.sv
// Module: free-running up-counter with a period wrap and a synchronous stop.
// Assumes the period limit may shrink below the current count at any time.
module aux_pwm_counter #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [DW-1:0] per_live,
    output logic [DW-1:0] count,
    output logic          wrap
);
    // Wrap when the count reaches or passes the limit, so shrinking never strands it.
    always_comb wrap = run && (count >= per_live);

    // Count up, return to zero at the wrap or while stopped.
    always_ff @(posedge clk) begin
        if (!rst_n)    count <= '0;
        else if (!run) count <= '0;
        else if (wrap) count <= '0;
        else           count <= count + 1'b1;
    end

    // R2: the counter returns to zero after a wrap
    a_r2_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (count == '0));

    // R2: below the limit the counter steps by one
    a_r2_step_by_one: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !wrap) |=> (count == $past(count) + 1'b1));

    // R3: a cleared run bit zeroes the counter
    a_r3_stop_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (count == '0));
endmodule

// File: rtl/aux_pwm_out.sv
// Module: compare, polarity and mode gating into a registered output pin.
// Assumes count and compare come from registers, so the output register is glitch-free.
module aux_pwm_out #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mode,
    input  logic          pol,
    input  logic [DW-1:0] count,
    input  logic [DW-1:0] cmp_live,
    output logic          pwm_out
);
    logic below;

    // Raw active phase: counter under the compare value.
    always_comb below = (count < cmp_live);

    // Register the gated, polarity-adjusted output.
    always_ff @(posedge clk) begin
        if (!rst_n) pwm_out <= 1'b0;
        else        pwm_out <= mode & (below ^ pol);
    end

    // R6: output mode off forces the pin low
    a_r6_mode_off_low: assert property (@(posedge clk) disable iff (!rst_n)
        !mode |=> !pwm_out);

    // R5: inverted polarity puts the pin low in the compare phase
    a_r5_inverted_low: assert property (@(posedge clk) disable iff (!rst_n)
        (mode && pol && count < cmp_live) |=> !pwm_out);
endmodule

// File: rtl/aux_pwm.sv
// Module: top of the auxiliary PWM generator; wires registers, counter and output stage.
// Assumes a single clock domain and one register write per cycle.
module aux_pwm
    import aux_pwm_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int CW = CTRL_W,
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          pwm_out
);
    logic [CW-1:0] ctrl;
    logic [DW-1:0] per_live, cmp_live, count;
    logic          wrap;

    aux_pwm_regs #(.DW(DW), .CW(CW), .AW(AW)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .wrap(wrap), .count(count),
        .ctrl(ctrl), .per_live(per_live), .cmp_live(cmp_live)
    );

    aux_pwm_counter #(.DW(DW)) u_counter (
        .clk(clk), .rst_n(rst_n),
        .run(ctrl[BIT_RUN]), .per_live(per_live),
        .count(count), .wrap(wrap)
    );

    aux_pwm_out #(.DW(DW)) u_out (
        .clk(clk), .rst_n(rst_n),
        .mode(ctrl[BIT_MODE]), .pol(ctrl[BIT_POL]),
        .count(count), .cmp_live(cmp_live),
        .pwm_out(pwm_out)
    );
endmodule

// File: tb/aux_pwm_bench.sv
`timescale 1ns/1ps
module aux_pwm_bench;
    localparam int DW = 32;
    localparam int AW = 5;
    localparam logic [31:0] C_RUN  = 32'h0010;
    localparam logic [31:0] C_MODE = 32'h0200;
    localparam logic [31:0] C_POL  = 32'h0400;
    localparam logic [31:0] C_SYNC = 32'h00C0;
    localparam int NWIN = 4;

    typedef struct packed {
        logic [15:0] per;
        logic [15:0] cmp;
        logic        pol;
        logic        sync;
        logic [15:0] hi;
        logic [3:0]  rises;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{per: 16'd9,  cmp: 16'd3,  pol: 1'b0, sync: 1'b0, hi: 16'd3,  rises: 4'd1},  // R4
        '{per: 16'd9,  cmp: 16'd3,  pol: 1'b1, sync: 1'b1, hi: 16'd7,  rises: 4'd1},  // R5, R10
        '{per: 16'd4,  cmp: 16'd0,  pol: 1'b0, sync: 1'b0, hi: 16'd0,  rises: 4'd0},  // R4
        '{per: 16'd4,  cmp: 16'd0,  pol: 1'b1, sync: 1'b0, hi: 16'd5,  rises: 4'd0},  // R5
        '{per: 16'd7,  cmp: 16'd8,  pol: 1'b0, sync: 1'b1, hi: 16'd8,  rises: 4'd0},  // R11
        '{per: 16'd1,  cmp: 16'd1,  pol: 1'b0, sync: 1'b0, hi: 16'd1,  rises: 4'd1},  // R9
        '{per: 16'd15, cmp: 16'd15, pol: 1'b0, sync: 1'b0, hi: 16'd15, rises: 4'd1},  // R2
        '{per: 16'd6,  cmp: 16'd9,  pol: 1'b1, sync: 1'b0, hi: 16'd0,  rises: 4'd0}   // R11
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic          pwm_out;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    aux_pwm u_aux_pwm (
        .clk(clk), .rst_n(rst_n),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .pwm_out(pwm_out)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input int addr, input logic [31:0] data);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = AW'(addr); bus_wdata = data;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input int addr, output logic [31:0] data);
        @(negedge clk);
        bus_addr = AW'(addr);
        #1 data = bus_rdata;
    endtask

    task automatic measure(input int per, output int highs, output int rises);
        logic prev;
        highs = 0; rises = 0;
        prev = pwm_out;
        for (int i = 0; i < NWIN * (per + 1); i++) begin
            @(negedge clk);
            if (pwm_out) highs++;
            if (pwm_out && !prev) rises++;
            prev = pwm_out;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] d;
        int h, r;
        bit seen;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        check("R1 pwm_out", {31'd0, pwm_out}, 0);
        rd('h00, d); check("R1 ctrl", d, 0);
        rd('h04, d); check("R1 period", d, 0);
        rd('h08, d); check("R1 compare", d, 0);
        rd('h0C, d); check("R1 staged period", d, 0);
        rd('h10, d); check("R1 staged compare", d, 0);
        rd('h14, d); check("R1 count", d, 0);

        // R10: control read-back and unmapped offset
        wr('h00, 32'h0000_A5C3);
        rd('h00, d); check("R10 ctrl readback", d, 32'h0000_A5C3);
        rd('h18, d); check("R10 unmapped", d, 0);
        wr('h00, 0);

        // Vector table: R2 R4 R5 R9 R10 R11
        for (int v = 0; v < NV; v++) begin
            wr('h00, 0);
            wr('h04, 32'(VECS[v].per));
            wr('h08, 32'(VECS[v].cmp));
            wr('h00, C_RUN | C_MODE | (VECS[v].pol ? C_POL : 0) | (VECS[v].sync ? C_SYNC : 0));
            repeat (3 * (VECS[v].per + 1) + 4) @(negedge clk);
            measure(VECS[v].per, h, r);
            check($sformatf("R4/R5/R11 vec%0d highs", v), h, NWIN * VECS[v].hi);
            check($sformatf("R2/R9 vec%0d rises", v), r, NWIN * VECS[v].rises);
        end

        // R7: staged write mid-period, old period completes, then transfer
        wr('h00, 0);
        wr('h04, 9);
        wr('h08, 3);
        wr('h00, C_RUN | C_MODE);
        d = 0;
        for (int i = 0; i < 40 && d != 2; i++) rd('h14, d);
        wr('h0C, 4);
        wr('h10, 2);
        rd('h04, d); check("R7 live period held", d, 9);
        rd('h08, d); check("R7 live compare held", d, 3);
        seen = 0;
        for (int i = 0; i < 12; i++) begin
            rd('h14, d);
            if (d == 9) seen = 1;
        end
        check("R7 old period completed", {31'd0, seen}, 1);
        rd('h04, d); check("R7 period transferred", d, 4);
        rd('h08, d); check("R7 compare transferred", d, 2);
        repeat (10) @(negedge clk);
        measure(4, h, r);
        check("R7 new waveform highs", h, NWIN * 2);

        // R8: live write cancels pending transfer
        wr('h0C, 6);
        wr('h04, 5);
        wr('h08, 2);
        repeat (30) @(negedge clk);
        rd('h04, d); check("R8 live period kept", d, 5);
        rd('h0C, d); check("R8 staged period kept", d, 6);
        measure(5, h, r);
        check("R8 waveform highs", h, NWIN * 2);

        // R3: clearing run zeroes and holds the counter
        wr('h00, C_MODE);
        rd('h14, d); check("R3 count zero", d, 0);
        repeat (10) @(negedge clk);
        rd('h14, d); check("R3 count held", d, 0);

        // R6: mode off keeps the pin low while counting
        wr('h00, C_RUN);
        repeat (4) @(negedge clk);
        measure(5, h, r);
        check("R6 mode off highs", h, 0);
        rd('h14, d);
        check("R6 counter running", {31'd0, d <= 5}, 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule